// File: doc/BRIEF.md
# Receiver Auto-Zero Sequencer

This block schedules the offset-cancellation cycles of a low-frequency receiver's input amplifier. While a cycle runs, it drives the digital control lines that cut the amplifier off from the pickup coil and tie the amplifier input to ground. It also freezes the decoded receive level, so the decoder downstream sees the last valid level and not the disturbance.

The block has two trigger modes. With data decoding disabled (carrier mode), every tick of the low-frequency oscillator period starts a cycle. With data decoding enabled (data mode), cycles are aligned to edges of the sliced data, and only one edge in every `EDGE_DIV` starts one. This keeps the cancellation away from the middle of a bit during preamble, sync and payload reception. A cycle lasts `AZ_CYCLES` periods of the oversampling clock. The default of 8 cycles at 125 kHz gives a window of about 64 µs. A trigger that arrives while a cycle is running is dropped.

Top module: `az_sequencer`

## Requirements
- R1: After reset, `az_busy_o` is 0, `amp_connect_o` is 1, `gnd_clamp_o` is 0 and `rx_data_o` is 0.
- R2: In carrier mode (`decode_en_i`=0), a `period_tick_i` pulse sampled while idle makes `az_busy_o` go high at the next clock edge.
- R3: Each accepted trigger keeps `az_busy_o` high for exactly `AZ_CYCLES` consecutive clock cycles. The default is 8.
- R4: While `az_busy_o` is 1, `amp_connect_o` is 0 and `gnd_clamp_o` is 1. While it is 0, the levels are reversed.
- R5: In data mode (`decode_en_i`=1), a 2-bit count of `data_edge_i` pulses starts at 0. Every edge advances it, including edges during a cycle. The edge that finds the count at `EDGE_DIV`-1 (3) wraps it to 0 and triggers a cycle, so the 4th, 8th, 12th… edges trigger.
- R6: In data mode, `period_tick_i` has no effect.
- R7: In carrier mode, `data_edge_i` has no effect.
- R8: A trigger that arrives while `az_busy_o` is 1 is ignored. The current cycle still ends after its original `AZ_CYCLES` cycles.
- R9: Any cycle with `decode_en_i`=0 clears the edge count to 0. After a return to data mode, the 4th new edge is the one that triggers.
- R10: When `az_busy_o` is 0 at a clock edge, `rx_data_o` takes the value of `rx_bit_i` at that edge. When it is 1, `rx_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| decode_en_i | input | 1 | 1 = data mode, 0 = carrier mode |
| period_tick_i | input | 1 | One-cycle pulse per low-frequency oscillator period |
| data_edge_i | input | 1 | One-cycle pulse per sliced data edge |
| rx_bit_i | input | 1 | Sliced receive level |
| rx_data_o | output | 1 | Receive level, frozen during auto-zero |
| az_busy_o | output | 1 | Auto-zero cycle in progress |
| amp_connect_o | output | 1 | Amplifier-to-coil switch enable |
| gnd_clamp_o | output | 1 | Amplifier input ground switch enable |

## Verification
The assertions assume the tick and edge inputs are clean single-cycle strobes and the mode bit is synchronous to the clock. They also assume the internal reset has been released, so the first checked edge follows a settled reset state. The bench drives every input at the falling edge and holds it for one full cycle. It waits out the reset synchronizer before any stimulus. Tick and edge spacings are swept from back-to-back up past the cycle length, so triggers land before, inside and right at the end of a running cycle.

// File: rtl/az_seq_pkg.sv
package az_seq_pkg;
  typedef enum logic {
    MODE_CARRIER = 1'b0,
    MODE_DATA    = 1'b1
  } az_mode_e;
endpackage

// File: rtl/az_rst_sync.sv
module az_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/az_trigger.sv
module az_trigger
  import az_seq_pkg::*;
#(
  parameter int EDGE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic decode_en_i,
  input  logic period_tick_i,
  input  logic data_edge_i,
  output logic start_o
);
  localparam int EW = (EDGE_DIV > 2) ? $clog2(EDGE_DIV) : 1;
  localparam logic [EW-1:0] LAST = EW'(EDGE_DIV - 1);

  az_mode_e mode;
  logic [EW-1:0] edge_q, edge_d;
  logic edge_en;
  logic at_last;

  assign mode    = az_mode_e'(decode_en_i);
  assign at_last = (edge_q == LAST);
  assign edge_en = (mode != MODE_DATA) || data_edge_i;

  always_comb begin
    edge_d = edge_q;
    if (mode != MODE_DATA)  edge_d = '0;
    else if (data_edge_i)   edge_d = at_last ? '0 : edge_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       edge_q <= '0;
    else if (edge_en) edge_q <= edge_d;
  end

  always_comb begin
    if (mode == MODE_DATA) start_o = data_edge_i && at_last;
    else                   start_o = period_tick_i;
  end

  // R9: leaving data mode clears the edge count
  a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en_i |=> (edge_q == '0));
  // R5: count moves only on an edge
  a_r5_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_en_i && !data_edge_i) |=> $stable(edge_q));
endmodule

// File: rtl/az_timer.sv
module az_timer #(
  parameter int AZ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (AZ_CYCLES > 2) ? $clog2(AZ_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(AZ_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d;
  logic accept;

  assign accept = start_i && !busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (accept) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept || busy_q) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R2: an idle trigger starts a cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);
  // R8: a trigger during a cycle does not reload the timer
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  // R3: a cycle starts with the full count
  a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == LOAD));
endmodule

// File: rtl/az_hold.sv
module az_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rx_bit_i,
  output logic rx_data_o
);
  logic rx_q, rx_d;
  logic upd_en;

  assign upd_en = !busy_i;

  always_comb begin
    rx_d = rx_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= 1'b0;
    else if (upd_en) rx_q <= rx_d;
  end

  assign rx_data_o = rx_q;

  // R10: level frozen during a cycle
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(rx_q));
  // R10: level tracks input when idle
  a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> (rx_q == $past(rx_bit_i)));
endmodule

// File: rtl/az_sequencer.sv
module az_sequencer #(
  parameter int AZ_CYCLES = 8,
  parameter int EDGE_DIV  = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic decode_en_i,
  input  logic period_tick_i,
  input  logic data_edge_i,
  input  logic rx_bit_i,
  output logic rx_data_o,
  output logic az_busy_o,
  output logic amp_connect_o,
  output logic gnd_clamp_o
);
  logic rst_int_n;
  logic start;
  logic busy;

  az_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  az_trigger #(.EDGE_DIV(EDGE_DIV)) u_trig (
    .clk(clk), .rst_n(rst_int_n), .decode_en_i(decode_en_i),
    .period_tick_i(period_tick_i), .data_edge_i(data_edge_i), .start_o(start)
  );

  az_timer #(.AZ_CYCLES(AZ_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .start_i(start), .busy_o(busy)
  );

  az_hold u_hold (
    .clk(clk), .rst_n(rst_int_n), .busy_i(busy),
    .rx_bit_i(rx_bit_i), .rx_data_o(rx_data_o)
  );

  assign az_busy_o     = busy;
  assign amp_connect_o = !busy;
  assign gnd_clamp_o   = busy;

  // R6: a lone tick in data mode never starts a cycle
  a_r6_tick_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (decode_en_i && !busy && !data_edge_i) |=> !busy);
  // R7: a lone edge in carrier mode never starts a cycle
  a_r7_edge_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!decode_en_i && !busy && !period_tick_i) |=> !busy);
endmodule

// File: tb/tb_az_sequencer.sv
module tb_az_sequencer;
  localparam int N   = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic decode_en, tick, edge_s, rx_bit;
  logic rx_data, busy, amp, gnd;

  int n_chk = 0;
  int n_bad = 0;
  int m_rem, m_edges;
  logic m_busy, m_out;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  az_sequencer dut (
    .clk(clk), .rst_n(rst_n), .decode_en_i(decode_en),
    .period_tick_i(tick), .data_edge_i(edge_s), .rx_bit_i(rx_bit),
    .rx_data_o(rx_data), .az_busy_o(busy),
    .amp_connect_o(amp), .gnd_clamp_o(gnd)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, advance reference, compare after posedge
  task automatic step(input string tag, input logic mode, input logic tk,
                      input logic ed, input logic bt);
    logic trig;
    @(negedge clk);
    decode_en = mode; tick = tk; edge_s = ed; rx_bit = bt;
    trig = mode ? (ed && m_edges == DIV - 1) : tk;
    if (!mode)   m_edges = 0;
    else if (ed) m_edges = (m_edges + 1) % DIV;
    if (!m_busy) m_out = bt;
    if (m_busy) begin
      m_rem--;
      m_busy = (m_rem > 0);
    end else if (trig) begin
      m_rem = N;
      m_busy = 1'b1;
    end
    @(posedge clk); #1;
    chk(tag, busy, m_busy);
    chk("R4", amp, !m_busy);
    chk("R4", gnd, m_busy);
    chk("R10", rx_data, m_out);
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    rst_n = 1'b0; decode_en = 1'b0; tick = 1'b0; edge_s = 1'b0; rx_bit = 1'b0;
    m_rem = 0; m_edges = 0; m_busy = 1'b0; m_out = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", busy, 1'b0); chk("R1", amp, 1'b1);
    chk("R1", gnd, 1'b0);  chk("R1", rx_data, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2/R3: single tick, measure busy length directly
    step("R2", 1'b0, 1'b1, 1'b0, 1'b1);
    len = 0;
    for (int i = 0; i < 3 * N; i++) begin
      if (busy) len++;
      step("R3", 1'b0, 1'b0, 1'b0, rnd());
    end
    n_chk++;
    if (len != N) begin
      n_bad++;
      $display("FAIL R3: actual %0d expected %0d", len, N);
    end

    // R8: tick spacing sweep in carrier mode, edges present (R7)
    for (int gap = 1; gap <= 2 * N + 2; gap++)
      for (int i = 0; i < 6 * gap + 2 * N; i++)
        step("R8", 1'b0, (i % gap) == 0, rnd(), rnd());

    // R5/R6: edge spacing sweep in data mode, ticks present
    for (int gap = 1; gap <= 2 * N + 2; gap++)
      for (int i = 0; i < 10 * gap + 2 * N; i++)
        step("R5", 1'b1, rnd(), (i % gap) == 0, rnd());

    // R9: leave data mode after k edges, return and count afresh
    for (int k = 0; k < DIV; k++) begin
      for (int i = 0; i < 2 * N; i++) step("R9", 1'b0, 1'b0, 1'b0, rnd());
      for (int i = 0; i < k; i++) step("R9", 1'b1, 1'b0, 1'b1, rnd());
      step("R9", 1'b0, 1'b0, 1'b1, rnd());
      for (int i = 0; i < DIV * (N + 1); i++)
        step("R9", 1'b1, 1'b0, (i % (N + 1)) == 0, rnd());
    end

    // mixed random traffic with mode changes
    for (int i = 0; i < 4000; i++)
      step("R7", (i / 97) % 2 == 1, rnd() & rnd(), rnd(), rnd());

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule